// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is the 32-bit status and control word that sits beside a floating-point arithmetic unit. Each time the arithmetic unit finishes an operation, it presents five exception indications on a one-cycle strobe. The block then replaces its per-operation flag field with those indications and accumulates them into a sticky cause field. If any accumulated cause is also enabled, the block raises a one-cycle exception request that carries a fixed vector code.

Software can overwrite the word through a load port. Only the implemented bits are kept; every other bit reads back as zero. Two control fields are decoded and sent back to the datapath. The rounding field selects either truncation toward zero or round-to-nearest-even. The denormal bit drives the flush-to-zero input directly.

Compare operations are handled separately. An ordered compare result leaves the word untouched. Only an unordered compare goes through the normal exception update.

Top module: `fpstat_reg`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `stat_q` reads 0x00040001. `exc_req` reads 0 and `exc_vector` reads 0.
- R2: A load stores `ld_data & 0x0005FFFF`. Bits 31:19 and bit 17 always read 0.
- R3: `rnd_zero` is 1 exactly when bits [1:0] equal 2'b01. The values 00, 10 and 11 give 0, which means round to nearest even.
- R4: `flush_zero` follows bit 18 of the register.
- R5: An accepted operation replaces flag bits [6:2] with `exc_in`. The mapping is `exc_in[4]`=invalid→bit 6, `exc_in[3]`=divide-by-zero→bit 5, `exc_in[2]`=overflow→bit 4, `exc_in[1]`=underflow→bit 3 and `exc_in[0]`=inexact→bit 2.
- R6: An accepted operation with nonzero `exc_in` ORs `exc_in` into cause bits [16:12], in the same order shifted up by 10. An operation never clears a cause bit.
- R7: `exc_req` is high for exactly one cycle, the cycle after an accepted operation with nonzero `exc_in` whose updated cause ANDed with enable bits [11:7] is nonzero. `exc_vector` is 0x120 while `exc_req` is high and 0 otherwise.
- R8: An accepted operation with `exc_in` equal to 0 clears the flags, leaves the cause unchanged and raises no request, even when an enabled cause is already pending.
- R9: A compare operation (`op_is_cmp`=1) with `cmp_unord`=0 leaves the register unchanged and raises no request. With `cmp_unord`=1 it is handled like any other operation.
- R10: A load in the same cycle as an operation wins. The loaded value is stored and no request is raised.
- R11: An operation never changes the rounding field, the enable field or the denormal bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Software load value |
| op_valid | input | 1 | Operation result strobe |
| op_is_cmp | input | 1 | The operation is a compare |
| cmp_unord | input | 1 | The compare result is unordered |
| exc_in | input | 5 | Exception indications {invalid, div-zero, overflow, underflow, inexact} |
| stat_q | output | 32 | Register value |
| exc_req | output | 1 | Exception request pulse |
| exc_vector | output | 12 | Vector code, valid with exc_req |
| rnd_zero | output | 1 | 1 = round toward zero, 0 = round to nearest even |
| flush_zero | output | 1 | Flush-to-zero control for the datapath |

## Verification
The assertions assume the inputs are known and stable at every rising edge. They also assume `rst` is high from time zero, so the reset check has a defined previous sample. They do not assume anything about `cmp_unord` when `op_is_cmp` is low, and they do not assume that loads and operations are mutually exclusive.

The stimulus drives all inputs on falling edges and keeps them for a full cycle. It deliberately overlaps a load with an operation, and it issues ordered and unordered compares that carry nonzero exception inputs. This exercises the priority and qualification rules without going outside the assumptions above.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int STAT_W      = 32;
  localparam int NEXC        = 5;
  localparam int RM_LSB      = 0;
  localparam int RM_W        = 2;
  localparam int FLAG_LSB    = 2;
  localparam int EN_LSB      = FLAG_LSB + NEXC;
  localparam int CAUSE_LSB   = EN_LSB + NEXC;
  localparam int CAUSE_SHIFT = CAUSE_LSB - FLAG_LSB;
  localparam int DN_BIT      = 18;
  localparam logic [STAT_W-1:0] WR_MASK   = 32'h0005_FFFF;
  localparam logic [STAT_W-1:0] RESET_VAL = 32'h0004_0001;
  localparam logic [RM_W-1:0]   RM_ZERO   = 2'b01;
endpackage

// File: rtl/fpstat_mode_dec.sv
module fpstat_mode_dec
  import fpstat_pkg::*;
(
  input  logic [RM_W-1:0] rm_field,
  input  logic            dn_bit,
  output logic            rnd_zero,
  output logic            flush_zero
);
  // only one encoding truncates; every other value rounds to nearest even
  always_comb begin
    rnd_zero   = (rm_field == RM_ZERO);
    flush_zero = dn_bit;
  end
endmodule

// File: rtl/fpstat_next.sv
module fpstat_next
  import fpstat_pkg::*;
(
  input  logic [STAT_W-1:0] cur,
  input  logic              ld_en,
  input  logic [STAT_W-1:0] ld_data,
  input  logic              op_upd,
  input  logic [NEXC-1:0]   exc,
  output logic [STAT_W-1:0] nxt,
  output logic              raise
);
  logic [STAT_W-1:0] flag_vec;
  logic [STAT_W-1:0] cause_vec;
  logic [STAT_W-1:0] cleared;
  logic [NEXC-1:0]   cause_new;

  always_comb begin
    flag_vec  = STAT_W'(exc) << FLAG_LSB;
    cause_vec = flag_vec << CAUSE_SHIFT;
    cleared   = cur & ~(STAT_W'({NEXC{1'b1}}) << FLAG_LSB);
    cause_new = cur[CAUSE_LSB +: NEXC] | exc;
    nxt       = cur;
    raise     = 1'b0;
    if (ld_en) begin
      nxt = ld_data & WR_MASK;
    end else if (op_upd) begin
      nxt = cleared | flag_vec;
      if (|exc) begin
        nxt   = nxt | cause_vec;
        raise = |(cause_new & cur[EN_LSB +: NEXC]);
      end
    end
  end
endmodule

// File: rtl/fpstat_reg.sv
module fpstat_reg
  import fpstat_pkg::*;
#(
  parameter int               VEC_W    = 12,
  parameter logic [VEC_W-1:0] VEC_CODE = 12'h120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [STAT_W-1:0] ld_data,
  input  logic              op_valid,
  input  logic              op_is_cmp,
  input  logic              cmp_unord,
  input  logic [NEXC-1:0]   exc_in,
  output logic [STAT_W-1:0] stat_q,
  output logic              exc_req,
  output logic [VEC_W-1:0]  exc_vector,
  output logic              rnd_zero,
  output logic              flush_zero
);
  logic              op_upd;
  logic [STAT_W-1:0] stat_d;
  logic              raise_d;

  // ordered compares only set the condition bit elsewhere; no status change
  assign op_upd = op_valid & (~op_is_cmp | cmp_unord);

  fpstat_next u_next (
    .cur     (stat_q),
    .ld_en   (ld_en),
    .ld_data (ld_data),
    .op_upd  (op_upd),
    .exc     (exc_in),
    .nxt     (stat_d),
    .raise   (raise_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q     <= RESET_VAL;
      exc_req    <= 1'b0;
      exc_vector <= '0;
    end else begin
      stat_q     <= stat_d;
      exc_req    <= raise_d;
      exc_vector <= raise_d ? VEC_CODE : '0;
    end
  end

  fpstat_mode_dec u_dec (
    .rm_field   (stat_q[RM_LSB +: RM_W]),
    .dn_bit     (stat_q[DN_BIT]),
    .rnd_zero   (rnd_zero),
    .flush_zero (flush_zero)
  );
endmodule

// File: rtl/fpstat_chk.sv
module fpstat_chk
  import fpstat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ld_en,
  input logic [STAT_W-1:0] ld_data,
  input logic              op_valid,
  input logic              op_is_cmp,
  input logic              cmp_unord,
  input logic [NEXC-1:0]   exc_in,
  input logic [STAT_W-1:0] stat_q,
  input logic              exc_req,
  input logic [11:0]       exc_vector,
  input logic              rnd_zero,
  input logic              flush_zero
);
  // R1
  reset_value_chk: assert property (@(posedge clk)
    rst |=> (stat_q == RESET_VAL && !exc_req && exc_vector == '0));

  // R2
  load_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> stat_q == ($past(ld_data) & WR_MASK));

  // R3
  round_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> rnd_zero == ($past(ld_data[1:0]) == 2'b01));

  // R4
  flush_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> flush_zero == $past(ld_data[DN_BIT]));

  // R6
  cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ld_en) |=>
      ((stat_q[CAUSE_LSB +: NEXC] & $past(stat_q[CAUSE_LSB +: NEXC]))
        == $past(stat_q[CAUSE_LSB +: NEXC])));

  // R7
  vector_code_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> exc_vector == 12'h120);

  // R7
  vector_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> exc_vector == 12'h000);

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_req && !op_valid) |=> !exc_req);

  // R8
  no_exc_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ld_en && exc_in == '0) |=> !exc_req);

  // R9
  ordered_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_is_cmp && !cmp_unord && !ld_en) |=>
      ($stable(stat_q) && !exc_req));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> !exc_req);

  // R11
  ctrl_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> ($stable(stat_q[RM_LSB +: RM_W]) && $stable(stat_q[EN_LSB +: NEXC])
                && $stable(stat_q[DN_BIT])));
endmodule

bind fpstat_reg fpstat_chk u_chk (.*);

// File: tb/tb_fpstat_reg.sv
`timescale 1ns/1ps
module tb_fpstat_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic        op_valid = 1'b0;
  logic        op_is_cmp = 1'b0;
  logic        cmp_unord = 1'b0;
  logic [4:0]  exc_in = '0;
  logic [31:0] stat_q;
  logic        exc_req;
  logic [11:0] exc_vector;
  logic        rnd_zero;
  logic        flush_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] stat;
    logic        req;
    string       tag;
  } item_t;
  item_t exp_q[$];
  logic [31:0] model = 32'h0004_0001;

  always #2 clk = ~clk;

  fpstat_reg dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_data(ld_data),
    .op_valid(op_valid), .op_is_cmp(op_is_cmp), .cmp_unord(cmp_unord),
    .exc_in(exc_in), .stat_q(stat_q), .exc_req(exc_req),
    .exc_vector(exc_vector), .rnd_zero(rnd_zero), .flush_zero(flush_zero)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the predicted outcome
  task automatic step(input logic r, input logic l, input logic [31:0] d,
                      input logic op, input logic cmp, input logic unord,
                      input logic [4:0] e, input string tag);
    item_t it;
    logic req;
    @(negedge clk);
    rst = r; ld_en = l; ld_data = d; op_valid = op;
    op_is_cmp = cmp; cmp_unord = unord; exc_in = e;
    req = 1'b0;
    if (r) model = 32'h0004_0001;
    else if (l) model = d & 32'h0005_FFFF;
    else if (op && (!cmp || unord)) begin
      model[6:2] = e;
      if (e != 5'd0) begin
        model[16:12] = model[16:12] | e;
        req = |(model[16:12] & model[11:7]);
      end
    end
    it.stat = model; it.req = req; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 5'h0, tag);
  endtask

  task automatic load(input logic [31:0] d, input string tag);
    step(1'b0, 1'b1, d, 1'b0, 1'b0, 1'b0, 5'h0, tag);
  endtask

  task automatic op(input logic [4:0] e, input string tag);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, e, tag);
  endtask

  // monitor: compares outputs one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.tag, "stat_q", stat_q, it.stat);
        chk(it.tag, "exc_req", {31'h0, exc_req}, {31'h0, it.req});
        chk(it.tag, "exc_vector", {20'h0, exc_vector}, it.req ? 32'h120 : 32'h0);
        chk(it.tag, "rnd_zero", {31'h0, rnd_zero}, {31'h0, it.stat[1:0] == 2'b01});
        chk(it.tag, "flush_zero", {31'h0, flush_zero}, {31'h0, it.stat[18]});
      end
    end
  end

  initial begin
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 5'h0, "R1 reset");
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 5'h0, "R1 reset");
    idle("R1 hold after reset");
    load(32'hFFFF_FFFF, "R2 R3 R4 masked all-ones");
    load(32'h0000_0000, "R2 R4 zero");
    load(32'h0000_0001, "R3 rm 01");
    load(32'h0000_0002, "R3 rm 10");
    load(32'h0000_0003, "R3 rm 11");
    load(32'h0000_0000, "R2 clear");
    op(5'b10000, "R5 R6 invalid, not enabled");
    op(5'b00001, "R5 R6 inexact");
    op(5'b00000, "R8 clean op");
    load(32'h0000_0400, "R2 enable div-zero");
    op(5'b01000, "R7 div-zero enabled");
    idle("R7 pulse ends");
    op(5'b00001, "R7 sticky cause retriggers");
    op(5'b00000, "R8 no request with pending cause");
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 5'b10000, "R9 ordered compare");
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 5'b10000, "R9 unordered compare");
    step(1'b0, 1'b1, 32'h0004_0001, 1'b1, 1'b0, 1'b0, 5'b11111, "R10 load beats op");
    load(32'h0004_0F81, "R2 all enables");
    op(5'b00010, "R11 controls kept");
    op(5'b00100, "R11 R7 overflow");
    step(1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 5'b11111, "R1 reset during op");
    idle("R1 after reset");
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule